// File: doc/BRIEF.md
# Burst-Capable Microcontroller Bus Slave

This block is a synchronous slave port. It sits between a 16-bit microcontroller bus and a small word-addressed register file, and it runs on the bus clock. The host starts an access with a select strobe that is active low for one cycle. Address, direction and size are valid only at the clock edge where that strobe is sampled. The slave captures them at that edge. It then moves one or more 16-bit words and answers each word with a one-cycle active-low acknowledge. Transfer lengths above one word run as a burst, and the word address steps up by one for each acknowledged word.

Some requests are malformed or break the bus rules. In those cases the slave drives a one-cycle active-low transfer-error strobe and returns to idle. Three conditions cause this: a byte-size request, size lines that change while an access runs, and write data that is not valid when it is needed. On reads the slave enables its data-bus drivers for the whole access. The register file is external to the block and connects through a simple address, write-enable and data port.

Top module: `mcb_slave`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ack_n` and `err_n` are 1 and `drv_en` is 0.
- R2: An access starts only on a rising edge that samples `cs_n` low while `mode_en` is high and the slave is idle. If `mode_en` is low, the select is ignored: no acknowledge, no error, no drive and no write.
- R3: For a read, `drv_en` goes high in the cycle after the select edge. It stays high until the cycle after the last acknowledge, and it drops together with any error pulse. `drv_en` is never high for a write.
- R4: The size code is latched at the select edge. Code 2'b10 means one word, 2'b00 means two words and 2'b11 means eight words. The slave gives exactly that many acknowledge pulses. Each pulse is one cycle low, and the pulses fall in consecutive cycles starting in the cycle after the select edge.
- R5: The address is latched at the select edge. Word k of a burst uses address (base + k) mod 128. Read data for a word is on `rdata` in the same cycle as that word's acknowledge.
- R6: Size code 2'b01 (one byte) is illegal. `err_n` goes low for the one cycle after the select edge, with no acknowledge and no register-file write.
- R7: If the size lines differ from the latched code at any rising edge while an access is active (including the edge that ends it), the slave drops `err_n` for one cycle. It gives no further acknowledges and returns to idle.
- R8: On a write, `wvalid` must be high at every edge that moves a word, starting one edge after the select edge. If `wvalid` is low at such an edge, the slave pulses `err_n`, does not write that word and aborts.
- R9: Each written word stores `wdata` at (base + k) mod 128 and is acknowledged in the following cycle. Data written this way reads back unchanged.
- R10: `ack_n` and `err_n` are never low in the same cycle, and after an error pulse the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_en | input | 1 | Enables this bus mode; select is ignored while low |
| cs_n | input | 1 | Access start strobe, active low for one cycle |
| rd_wr | input | 1 | Direction: 1 = read, 0 = write |
| size | input | 2 | Transfer size code |
| addr | input | 7 | Word address, valid at the select edge only |
| wdata | input | 16 | Write data from the host |
| wvalid | input | 1 | Write data present on `wdata` |
| ack_n | output | 1 | Per-word acknowledge, active low |
| err_n | output | 1 | Transfer-error pulse, active low |
| drv_en | output | 1 | Data-bus driver enable for reads |
| rdata | output | 16 | Read data toward the host |
| rf_addr | output | 7 | Register-file word address |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 16 | Register-file write data |
| rf_rdata | input | 16 | Register-file read data for `rf_addr` |

## Verification
Several rules are checked on every cycle:
- acknowledge and error are never low together;
- a byte request or a size mismatch is followed by an error pulse;
- a write acknowledge never follows an edge without valid data;
- the driver enable never rises on a write;
- the burst address steps by exactly one, wrapping modulo 128.

Other properties need the bench's scenarios. These are the exact count of acknowledges per size code, the read data seen at each acknowledge, wrap-around at the top of the word space, the abort point inside a burst, and write-then-read consistency of the register file. The bench checks them against its own model.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    typedef enum logic [1:0] {
        SZ_TWO   = 2'b00,
        SZ_BYTE  = 2'b01,
        SZ_ONE   = 2'b10,
        SZ_EIGHT = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic  is_read;
        size_e size;
    } access_t;

    localparam int unsigned MAX_BURST_WORDS = 8;

    function automatic int unsigned words_of(size_e sz);
        case (sz)
            SZ_ONE:   words_of = 1;
            SZ_TWO:   words_of = 2;
            SZ_EIGHT: words_of = MAX_BURST_WORDS;
            default:  words_of = 0;
        endcase
    endfunction

endpackage

// File: rtl/mcb_addr_step.sv
module mcb_addr_step #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= base;
        end else if (step) begin
            cur <= cur + ADDR_W'(1);
        end
    end

    // R5: burst address advances by one, wrapping in the word space
    p_step_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (cur == $past(cur) + ADDR_W'(1)));

    p_load_base_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == $past(base)));

endmodule

// File: rtl/mcb_fault_chk.sv
module mcb_fault_chk
    import mcb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  size_e start_size,
    input  logic  busy,
    input  size_e held_size,
    input  size_e size_now,
    input  logic  data_edge,
    input  logic  wvalid,
    output logic  byte_fault,
    output logic  size_fault,
    output logic  late_fault
);

    always_comb begin
        byte_fault = start && (start_size == SZ_BYTE);
        size_fault = busy && (size_now != held_size);
        late_fault = data_edge && !wvalid;
    end

    // R6: a byte request never enters an active access
    p_byte_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
        byte_fault |-> !busy);

    // R8: a late-data fault only exists while moving write words
    p_late_in_xfer_r8: assert property (@(posedge clk) disable iff (rst)
        late_fault |-> busy);

endmodule

// File: rtl/mcb_seq.sv
module mcb_seq
    import mcb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_read,
    input  size_e             start_size,
    input  logic              wvalid,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic              byte_fault,
    input  logic              size_fault,
    input  logic              late_fault,
    output logic              busy,
    output logic              data_edge,
    output size_e             held_size,
    output logic              load,
    output logic              step,
    output logic              rf_we,
    output logic              ack_n,
    output logic              err_n,
    output logic              drv_en,
    output logic [DATA_W-1:0] rdata
);

    seq_state_e       st;
    access_t          held;
    logic [CNT_W-1:0] left;
    logic             any_fault;

    always_comb begin
        busy      = (st != ST_IDLE);
        held_size = held.size;
        data_edge = (st == ST_XFER) && !held.is_read;
        any_fault = size_fault || late_fault;
        load      = start && !byte_fault;
        step      = (st == ST_XFER) && !any_fault;
        rf_we     = step && !held.is_read;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            held    <= '{is_read: 1'b0, size: SZ_ONE};
            left    <= '0;
            ack_n   <= 1'b1;
            err_n   <= 1'b1;
            drv_en  <= 1'b0;
            rdata   <= '0;
        end else begin
            ack_n <= 1'b1;
            err_n <= 1'b1;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (byte_fault) begin
                            err_n <= 1'b0;
                        end else begin
                            st      <= ST_XFER;
                            held    <= '{is_read: start_read, size: start_size};
                            left    <= CNT_W'(words_of(start_size));
                            drv_en  <= start_read;
                        end
                    end
                end
                ST_XFER: begin
                    if (any_fault) begin
                        err_n  <= 1'b0;
                        drv_en <= 1'b0;
                        st     <= ST_IDLE;
                    end else begin
                        ack_n <= 1'b0;
                        if (held.is_read) begin
                            rdata <= rf_rdata;
                        end
                        left <= left - CNT_W'(1);
                        if (left == CNT_W'(1)) begin
                            st <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    st     <= ST_IDLE;
                    drv_en <= 1'b0;
                    if (size_fault) begin
                        err_n <= 1'b0;
                    end
                end
                default: begin
                    st     <= ST_IDLE;
                    drv_en <= 1'b0;
                end
            endcase
        end
    end

    // R10: acknowledge and error strobes are exclusive
    p_ack_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!ack_n && !err_n));

    // R10: after an error pulse the sequencer is idle
    p_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !err_n |-> (st == ST_IDLE));

    // R4: acknowledges only come out of an active access
    p_ack_busy_r4: assert property (@(posedge clk) disable iff (rst)
        !ack_n |-> busy);

    // R3: the bus driver is never enabled for a write
    p_drv_read_r3: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (busy && held.is_read));

    // R8: a write acknowledge follows an edge with valid data
    p_wr_ack_data_r8: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !held.is_read) |-> $past(wvalid));

    // R6: a byte request gives an error pulse and no acknowledge
    p_byte_err_r6: assert property (@(posedge clk) disable iff (rst)
        (start && byte_fault) |=> (!err_n && ack_n));

    // R7: a size mismatch aborts with an error pulse
    p_size_abort_r7: assert property (@(posedge clk) disable iff (rst)
        size_fault |=> (!err_n && ack_n && !drv_en));

endmodule

// File: rtl/mcb_slave.sv
module mcb_slave
    import mcb_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 16,
    parameter int MAX_WORDS = MAX_BURST_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_en,
    input  logic              cs_n,
    input  logic              rd_wr,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wvalid,
    output logic              ack_n,
    output logic              err_n,
    output logic              drv_en,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);

    localparam int CNT_W = $clog2(MAX_WORDS + 1);

    size_e size_now;
    size_e held_size;
    logic  busy;
    logic  start;
    logic  data_edge;
    logic  load;
    logic  step;
    logic  byte_fault;
    logic  size_fault;
    logic  late_fault;

    always_comb begin
        size_now = size_e'(size);
        start    = !cs_n && mode_en && !busy;
        rf_wdata = wdata;
    end

    mcb_fault_chk u_fault (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_size (size_now),
        .busy       (busy),
        .held_size  (held_size),
        .size_now   (size_now),
        .data_edge  (data_edge),
        .wvalid     (wvalid),
        .byte_fault (byte_fault),
        .size_fault (size_fault),
        .late_fault (late_fault)
    );

    mcb_seq #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_read (rd_wr),
        .start_size (size_now),
        .wvalid     (wvalid),
        .rf_rdata   (rf_rdata),
        .byte_fault (byte_fault),
        .size_fault (size_fault),
        .late_fault (late_fault),
        .busy       (busy),
        .data_edge  (data_edge),
        .held_size  (held_size),
        .load       (load),
        .step       (step),
        .rf_we      (rf_we),
        .ack_n      (ack_n),
        .err_n      (err_n),
        .drv_en     (drv_en),
        .rdata      (rdata)
    );

    mcb_addr_step #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .base (addr),
        .step (step),
        .cur  (rf_addr)
    );

    // R2: with the mode disabled a select starts nothing
    p_mode_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_en && !busy) |=> (err_n && ack_n && !drv_en));

    // R3: a read start enables the drivers on the next cycle
    p_read_drive_r3: assert property (@(posedge clk) disable iff (rst)
        (start && rd_wr && size_now != SZ_BYTE) |=> drv_en);

endmodule

// File: tb/mcb_slave_test.sv
`timescale 1ns/1ps
module mcb_slave_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_en = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_wr = 1'b1;
    logic [1:0]  size = 2'b10;
    logic [6:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wvalid = 1'b0;
    logic        ack_n, err_n, drv_en, rf_we;
    logic [15:0] rdata, rf_wdata, rf_rdata;
    logic [6:0]  rf_addr;

    logic [15:0] mem [128];
    logic [15:0] ref_mem [128];

    int total = 0;
    int bad = 0;
    int ack_cnt = 0;
    int err_cnt = 0;
    int both_low = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    mcb_slave uut (
        .clk(clk), .rst(rst), .mode_en(mode_en), .cs_n(cs_n), .rd_wr(rd_wr),
        .size(size), .addr(addr), .wdata(wdata), .wvalid(wvalid),
        .ack_n(ack_n), .err_n(err_n), .drv_en(drv_en), .rdata(rdata),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    assign rf_rdata = mem[rf_addr];

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i]     = 16'(i * 37 + 5);
            ref_mem[i] = 16'(i * 37 + 5);
        end
    end

    always @(posedge clk) begin
        if (rf_we) mem[rf_addr] <= rf_wdata;
    end

    // behavioural reference model
    logic        e_ack = 1'b1, e_err = 1'b1, e_drv = 1'b0;
    logic [15:0] e_rdata = '0;
    logic        m_busy = 1'b0, m_read = 1'b0;
    logic [1:0]  m_size = '0;
    logic [6:0]  m_base = '0;
    int          m_idx = 0, m_left = 0;

    function automatic int words(input logic [1:0] s);
        if (s == 2'b10) return 1;
        if (s == 2'b00) return 2;
        if (s == 2'b11) return 8;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            e_ack <= 1'b1; e_err <= 1'b1; e_drv <= 1'b0; m_busy <= 1'b0;
        end else begin
            e_ack <= 1'b1;
            e_err <= 1'b1;
            if (!m_busy) begin
                if (!cs_n && mode_en) begin
                    if (size == 2'b01) begin
                        e_err <= 1'b0;
                    end else begin
                        m_busy <= 1'b1; m_read <= rd_wr; m_size <= size;
                        m_base <= addr; m_idx <= 0; m_left <= words(size);
                        e_drv <= rd_wr;
                    end
                end
            end else if (size != m_size) begin
                e_err <= 1'b0; e_drv <= 1'b0; m_busy <= 1'b0;
            end else if (m_left == 0) begin
                e_drv <= 1'b0; m_busy <= 1'b0;
            end else if (!m_read && !wvalid) begin
                e_err <= 1'b0; m_busy <= 1'b0;
            end else begin
                e_ack <= 1'b0;
                if (m_read) e_rdata <= ref_mem[7'(m_base + 7'(m_idx))];
                else ref_mem[7'(m_base + 7'(m_idx))] <= wdata;
                m_idx <= m_idx + 1;
                m_left <= m_left - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(ack_n == e_ack, "R4", "ack_n", ack_n, e_ack);
            check(err_n == e_err, "R7", "err_n", err_n, e_err);
            check(drv_en == e_drv, "R3", "drv_en", drv_en, e_drv);
            if (!e_ack && m_read)
                check(rdata == e_rdata, "R5", "rdata", rdata, e_rdata);
            if (!ack_n) ack_cnt++;
            if (!err_n) err_cnt++;
            if (!ack_n && !err_n) both_low++;
        end
    end

    task automatic run(input logic rd, input logic [1:0] sz, input logic [6:0] a,
                       input logic men, input int late_at, input int chg_at,
                       input int exp_acks, input int exp_errs, input string req);
        int mism;
        ack_cnt = 0;
        err_cnt = 0;
        @(negedge clk);
        cs_n = 1'b0; rd_wr = rd; size = sz; addr = a; mode_en = men; wvalid = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            cs_n   = 1'b1;
            mode_en = 1'b1;
            addr   = 7'(a ^ 7'h55) + 7'(k);
            wdata  = 16'hA000 + 16'(k) + 16'(a);
            wvalid = (k != late_at);
            if (k == chg_at) size = sz ^ 2'b01;
        end
        @(negedge clk);
        wvalid = 1'b0;
        @(posedge clk); #1;
        check(ack_cnt == exp_acks, req, "ack count", ack_cnt, exp_acks);
        check(err_cnt == exp_errs, req, "error count", err_cnt, exp_errs);
        mism = 0;
        for (int i = 0; i < 128; i++) if (mem[i] !== ref_mem[i]) mism++;
        check(mism == 0, "R9", "register file mismatches", mism, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ack_n == 1'b1 && err_n == 1'b1 && drv_en == 1'b0, "R1",
              "reset outputs", {ack_n, err_n, drv_en}, 3'b110);
        rst = 1'b0;
        @(negedge clk);
        check(ack_n == 1'b1 && err_n == 1'b1 && drv_en == 1'b0, "R1",
              "after reset", {ack_n, err_n, drv_en}, 3'b110);

        run(1'b1, 2'b10, 7'd5,   1'b1, -1, -1, 1, 0, "R4");
        run(1'b1, 2'b00, 7'd40,  1'b1, -1, -1, 2, 0, "R4");
        run(1'b1, 2'b11, 7'd124, 1'b1, -1, -1, 8, 0, "R5");
        run(1'b0, 2'b10, 7'd10,  1'b1, -1, -1, 1, 0, "R9");
        run(1'b0, 2'b00, 7'd127, 1'b1, -1, -1, 2, 0, "R9");
        run(1'b0, 2'b11, 7'd120, 1'b1, -1, -1, 8, 0, "R9");
        run(1'b1, 2'b11, 7'd122, 1'b1, -1, -1, 8, 0, "R5");
        run(1'b1, 2'b01, 7'd3,   1'b1, -1, -1, 0, 1, "R6");
        run(1'b0, 2'b01, 7'd3,   1'b1, -1, -1, 0, 1, "R6");
        run(1'b1, 2'b11, 7'd20,  1'b0, -1, -1, 0, 0, "R2");
        run(1'b0, 2'b10, 7'd21,  1'b0, -1, -1, 0, 0, "R2");
        run(1'b1, 2'b11, 7'd60,  1'b1, -1,  3, 3, 1, "R7");
        run(1'b1, 2'b10, 7'd61,  1'b1, -1,  1, 1, 1, "R7");
        run(1'b0, 2'b10, 7'd70,  1'b1,  0, -1, 0, 1, "R8");
        run(1'b0, 2'b11, 7'd80,  1'b1,  5, -1, 5, 1, "R8");
        run(1'b1, 2'b11, 7'd80,  1'b1, -1, -1, 8, 0, "R9");

        check(both_low == 0, "R10", "ack and error low together", both_low, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule